// File: doc/BRIEF.md
# Per-Bucket Sender Credit Ledger

This block sits in a station that sends messages onto a ring of receivers. Each receiver splits its input storage into buckets. Every bucket on the ring has its own address. A sender may only put a message on the ring for a bucket while it holds a credit for that bucket. The ledger keeps one credit counter per bucket address. While the ledger is disabled, software loads each counter with its starting allowance. That value is also kept as the bucket's ceiling. A bucket that is never loaded keeps zero credits and can never be sent to.

Once enabled, the ledger answers a send request in the same cycle. The grant rises only when the named bucket holds at least one credit. A grant consumes one credit at the next clock edge. A credit-return pulse from a receiver restores one credit to the named bucket. A return that would lift a counter above its ceiling is discarded and latches a sticky error flag. Any bucket's count can be read through a combinational read port.

Top module: `ring_credit_ledger`

## Requirements
- R1: After reset every bucket reads 0 credits, the grant is low and the over-return flag is low.
- R2: While `enable` is low, a configuration write sets both the named bucket's count and its ceiling to `cfg_credits`. The new count is visible on `rd_credits` from the next cycle.
- R3: While `enable` is high, configuration writes have no effect on any count or ceiling.
- R4: `req_grant` is high in the same cycle exactly when `enable` and `req_vld` are high and the bucket named by `req_bkt` holds a nonzero count.
- R5: A grant lowers the requested bucket's count by one at the next edge and leaves every other bucket unchanged.
- R6: A request to a bucket with zero credits keeps the grant low. The request is neither consumed nor counted, and it is granted once a return has restored a credit while it is still held.
- R7: While enabled, a return to a bucket whose count is below its ceiling raises that count by one at the next edge.
- R8: A grant and a return to the same bucket in the same cycle leave that bucket's count unchanged and raise no error.
- R9: A return to a bucket already at its ceiling, with no grant to it in that cycle, leaves the count unchanged and sets `over_return_err`. The flag stays high until reset.
- R10: While `enable` is low, no request is granted and returns have no effect on counts or on the error flag.
- R11: A bucket whose ceiling is 0 is never granted, and a return to it sets `over_return_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High: grant and return operation. Low: configuration window |
| cfg_wr | input | 1 | Configuration write strobe, honoured only while disabled |
| cfg_bkt | input | IDX_W | Bucket addressed by the configuration write |
| cfg_credits | input | CNT_W | Starting credit count and ceiling to load |
| req_vld | input | 1 | Send request held by the station |
| req_bkt | input | IDX_W | Destination bucket of the send request |
| req_grant | output | 1 | Send may proceed this cycle; consumes one credit |
| ret_vld | input | 1 | Credit-return pulse from a receiver |
| ret_bkt | input | IDX_W | Bucket the returned credit belongs to |
| rd_bkt | input | IDX_W | Bucket selected for the credit read port |
| rd_credits | output | CNT_W | Current credit count of the selected bucket |
| over_return_err | output | 1 | Sticky flag: a return exceeded a bucket's ceiling |

## Verification
The bench builds the ledger with 8 buckets and 3-bit counters, so that every bucket and every count from 0 to 7 can be covered in one short run. Starting allowances are computed arithmetically and include a zero bucket and a full-scale bucket. After every cycle the bench reads back all eight buckets and compares them with its model. Each bucket is drained to zero and then refilled to its ceiling, so every decrement, every increment and both counter limits are exercised. The bench also covers the cases where a held request waits at zero, where a grant and a return hit the same bucket together, and where a return overruns the ceiling.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
   // Per-cycle action on one credit slot.
   typedef enum logic [1:0] {
      SLOT_IDLE = 2'b00,
      SLOT_TAKE = 2'b01,
      SLOT_GIVE = 2'b10,
      SLOT_BOTH = 2'b11
   } slot_op_e;
endpackage

// File: rtl/rcl_dec.sv
module rcl_dec #(
   parameter int N    = 8,
   parameter int IW   = 3
) (
   input  logic          en,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  hot
);
   for (genvar i = 0; i < N; i++) begin : g_line
      assign hot[i] = en && (idx == IW'(i));
   end
endmodule

// File: rtl/rcl_slot.sv
module rcl_slot
   import rcl_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] lim,
   output logic          reject
);
   logic [CW-1:0] cnt_q, lim_q;
   slot_op_e      op;
   logic          at_ceiling;

   assign op         = slot_op_e'({give, take});
   assign at_ceiling = (cnt_q == lim_q);
   assign reject     = (op == SLOT_GIVE) && at_ceiling;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         lim_q <= load_val;
      end else begin
         unique case (op)
            SLOT_TAKE: cnt_q <= cnt_q - CW'(1);
            SLOT_GIVE: if (!at_ceiling) cnt_q <= cnt_q + CW'(1);
            default:   cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt = cnt_q;
   assign lim = lim_q;
endmodule

// File: rtl/ring_credit_ledger.sv
module ring_credit_ledger #(
   parameter int NUM_BKT = 128,
   parameter int CNT_W   = 8,
   localparam int IDX_W  = $clog2(NUM_BKT),
   localparam int FLAT_W = NUM_BKT * CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cfg_wr,
   input  logic [IDX_W-1:0] cfg_bkt,
   input  logic [CNT_W-1:0] cfg_credits,
   input  logic             req_vld,
   input  logic [IDX_W-1:0] req_bkt,
   output logic             req_grant,
   input  logic             ret_vld,
   input  logic [IDX_W-1:0] ret_bkt,
   input  logic [IDX_W-1:0] rd_bkt,
   output logic [CNT_W-1:0] rd_credits,
   output logic             over_return_err
);
   // Elaboration-time parameter checks.
   if (NUM_BKT < 2 || (NUM_BKT & (NUM_BKT - 1)) != 0) begin : g_bad_num
      $error("NUM_BKT must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cw
      $error("CNT_W must lie between 1 and 16");
   end

   logic [FLAT_W-1:0]  cnt_flat;
   logic [FLAT_W-1:0]  lim_flat;
   logic [NUM_BKT-1:0] load_hot, take_hot, give_hot, reject_vec;
   logic [CNT_W-1:0]   req_cnt;
   logic               err_q;

   assign req_cnt    = cnt_flat[int'(req_bkt)*CNT_W +: CNT_W];
   assign req_grant  = enable && req_vld && (req_cnt != '0);
   assign rd_credits = cnt_flat[int'(rd_bkt)*CNT_W +: CNT_W];

   rcl_dec #(.N(NUM_BKT), .IW(IDX_W)) u_dec_load (
      .en (cfg_wr && !enable), .idx(cfg_bkt), .hot(load_hot));
   rcl_dec #(.N(NUM_BKT), .IW(IDX_W)) u_dec_take (
      .en (req_grant),         .idx(req_bkt), .hot(take_hot));
   rcl_dec #(.N(NUM_BKT), .IW(IDX_W)) u_dec_give (
      .en (enable && ret_vld), .idx(ret_bkt), .hot(give_hot));

   for (genvar b = 0; b < NUM_BKT; b++) begin : g_slot
      rcl_slot #(.CW(CNT_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load_hot[b]),
         .load_val (cfg_credits),
         .take     (take_hot[b]),
         .give     (give_hot[b]),
         .cnt      (cnt_flat[b*CNT_W +: CNT_W]),
         .lim      (lim_flat[b*CNT_W +: CNT_W]),
         .reject   (reject_vec[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_q | (|reject_vec);
   end

   assign over_return_err = err_q;
endmodule

// File: rtl/rcl_checker.sv
module rcl_checker #(
   parameter int NUM_BKT = 128,
   parameter int CNT_W   = 8,
   localparam int IDX_W  = $clog2(NUM_BKT),
   localparam int FLAT_W = NUM_BKT * CNT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              cfg_wr,
   input logic              req_vld,
   input logic [IDX_W-1:0]  req_bkt,
   input logic              req_grant,
   input logic              ret_vld,
   input logic [IDX_W-1:0]  ret_bkt,
   input logic              over_return_err,
   input logic [FLAT_W-1:0] cnt_flat,
   input logic [FLAT_W-1:0] lim_flat
);
   // R9: the error flag never falls without reset
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      over_return_err |=> over_return_err);

   // R5: a lone grant lowers the granted bucket by exactly one
   a_r5_grant_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant && !(ret_vld && ret_bkt == req_bkt))
      |=> cnt_flat[int'($past(req_bkt))*CNT_W +: CNT_W]
          == $past(cnt_flat[int'(req_bkt)*CNT_W +: CNT_W]) - CNT_W'(1));

   // R8: grant and return on one bucket cancel
   a_r8_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant && ret_vld && ret_bkt == req_bkt)
      |=> cnt_flat[int'($past(req_bkt))*CNT_W +: CNT_W]
          == $past(cnt_flat[int'(req_bkt)*CNT_W +: CNT_W]));

   // R3: ceilings are frozen while enabled
   a_r3_limits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(lim_flat));

   // R10: disabled and not configuring, counts hold
   a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !cfg_wr) |=> $stable(cnt_flat));

   // R9: no count ever exceeds its ceiling
   for (genvar b = 0; b < NUM_BKT; b++) begin : g_bound
      always @(posedge clk) begin
         if (rst_n) begin
            a_r9_within_limit: assert (cnt_flat[b*CNT_W +: CNT_W] <= lim_flat[b*CNT_W +: CNT_W]);
         end
      end
   end
endmodule

bind ring_credit_ledger rcl_checker #(.NUM_BKT(NUM_BKT), .CNT_W(CNT_W)) u_rcl_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .enable          (enable),
   .cfg_wr          (cfg_wr),
   .req_vld         (req_vld),
   .req_bkt         (req_bkt),
   .req_grant       (req_grant),
   .ret_vld         (ret_vld),
   .ret_bkt         (ret_bkt),
   .over_return_err (over_return_err),
   .cnt_flat        (cnt_flat),
   .lim_flat        (lim_flat)
);

// File: tb/tb_ring_credit_ledger.sv
`timescale 1ns/1ps
module tb_ring_credit_ledger;
   localparam int PER = 20;
   localparam int NB  = 8;
   localparam int CW  = 3;
   localparam int IW  = 3;

   logic          clk = 1'b0;
   logic          rst_n, enable, cfg_wr, req_vld, ret_vld;
   logic [IW-1:0] cfg_bkt, req_bkt, ret_bkt, rd_bkt;
   logic [CW-1:0] cfg_credits, rd_credits;
   logic          req_grant, over_return_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;
   int exp_cnt [NB];
   int exp_lim [NB];
   bit exp_err;

   always #(PER/2) clk = ~clk;

   ring_credit_ledger #(.NUM_BKT(NB), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_wr(cfg_wr), .cfg_bkt(cfg_bkt), .cfg_credits(cfg_credits),
      .req_vld(req_vld), .req_bkt(req_bkt), .req_grant(req_grant),
      .ret_vld(ret_vld), .ret_bkt(ret_bkt),
      .rd_bkt(rd_bkt), .rd_credits(rd_credits),
      .over_return_err(over_return_err));

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; enable = 1'b0; cfg_wr = 1'b0; req_vld = 1'b0; ret_vld = 1'b0;
      cfg_bkt = '0; cfg_credits = '0; req_bkt = '0; ret_bkt = '0; rd_bkt = '0;
      for (int k = 0; k < NB; k++) begin exp_cnt[k] = 0; exp_lim[k] = 0; end
      exp_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One cycle: read back all buckets, drive, check grant, clock, update model.
   task automatic cyc(input bit rq, input int rb, input bit rt, input int tb,
                      input bit cw, input int cb, input int cv, input string tag);
      bit g;
      for (int k = 0; k < NB; k++) begin
         rd_bkt = IW'(k);
         #1;
         check(tag, int'(rd_credits), exp_cnt[k], $sformatf("count of bucket %0d", k));
      end
      req_vld = rq; req_bkt = IW'(rb);
      ret_vld = rt; ret_bkt = IW'(tb);
      cfg_wr = cw;  cfg_bkt = IW'(cb); cfg_credits = CW'(cv);
      #1;
      g = enable && rq && (exp_cnt[rb] != 0);
      check(tag, int'(req_grant), int'(g), "grant");
      @(posedge clk);
      if (cw && !enable) begin exp_cnt[cb] = cv; exp_lim[cb] = cv; end
      if (g && !(rt && enable && tb == rb)) exp_cnt[rb]--;
      if (rt && enable && !(g && tb == rb)) begin
         if (exp_cnt[tb] < exp_lim[tb]) exp_cnt[tb]++;
         else exp_err = 1'b1;
      end
      @(negedge clk);
      req_vld = 1'b0; ret_vld = 1'b0; cfg_wr = 1'b0;
      check(tag, int'(over_return_err), int'(exp_err), "over-return flag");
   endtask

   initial begin
      #(PER * 50000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      cyc(1, 0, 0, 0, 0, 0, 0, "R1");

      // R2: load allowances (b*5+1) mod 8 -> bucket 3 gets 0, bucket 6 gets 7
      for (int b = 0; b < NB; b++) cyc(0, 0, 0, 0, 1, b, (b * 5 + 1) % 8, "R2");
      cyc(0, 0, 0, 0, 0, 0, 0, "R2");
      // R10: disabled request and return at ceiling do nothing
      cyc(1, 1, 1, 0, 0, 0, 0, "R10");

      enable = 1'b1;
      cyc(0, 0, 0, 0, 1, 0, 7, "R3");
      cyc(1, 6, 0, 0, 0, 0, 0, "R4");

      // R5: drain each bucket, then confirm the empty bucket stays ungranted
      for (int b = 0; b < NB; b++) begin
         while (exp_cnt[b] > 0) cyc(1, b, 0, 0, 0, 0, 0, "R5");
         cyc(1, b, 0, 0, 0, 0, 0, (b == 3) ? "R11" : "R6");
      end

      // R6: held request at zero, then a return releases it
      repeat (3) cyc(1, 2, 0, 0, 0, 0, 0, "R6");
      cyc(1, 2, 1, 2, 0, 0, 0, "R6");
      cyc(1, 2, 1, 2, 0, 0, 0, "R8");
      cyc(1, 2, 0, 0, 0, 0, 0, "R6");

      // R7: refill each bucket to its ceiling
      for (int b = 0; b < NB; b++)
         while (exp_cnt[b] < exp_lim[b]) cyc(0, 0, 1, b, 0, 0, 0, "R7");
      cyc(0, 0, 1, 7, 0, 0, 0, "R9");
      repeat (2) cyc(0, 0, 0, 0, 0, 0, 0, "R9");

      // R11: bucket with zero ceiling
      do_reset();
      cyc(0, 0, 0, 0, 0, 0, 0, "R1");
      enable = 1'b1;
      cyc(1, 3, 1, 3, 0, 0, 0, "R11");
      cyc(0, 0, 0, 0, 0, 0, 0, "R11");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule